// File: doc/BRIEF.md
# Sampling Tap Sweep Sequencer

This block runs the sweep phase of sampling-clock tuning in an SD/eMMC host controller. A start pulse makes it latch the number of taps that the delay line reports. It then probes every tap twice, in ring order. Each probe programs the tap position, raises a request to the command engine for one tuning command, and waits for the acknowledge. At the acknowledge it records one bit that says whether the command completed cleanly. It records a second bit that says whether the sampled-data comparator saw no mismatch. A fixed settling gap follows each probe.

When the sweep ends, the block presents the two bit vectors to an external window selector and holds them until the selector answers. On success it programs the chosen tap and turns on automatic re-tuning. On failure it clears all of its tuning state. It skips the sweep, and reports success, in three cases: the bus mode needs no tuning, the delay line reports no taps, or twice the tap count would overflow the mask.

Top module: `tap_sweep_seq`

## Requirements
- R1: With a reported tap count N, a sweep makes exactly 2N probes, and probe i drives `tapPos` = i mod N while its request is raised.
- R2: `cmdReq` stays high from the start of a probe until the cycle in which `cmdAck` is sampled, and each probe raises it exactly once.
- R3: Bit i of `passMask` is 1 exactly when `cmdErr` was 0 at the acknowledge of probe i.
- R4: Bit i of `matchMask` is 1 exactly when `cmpResult` was all zeros at the acknowledge of probe i.
- R5: Between the acknowledge of one probe and the request of the next, `cmdReq` is low for exactly SETTLE_CYC+1 cycles.
- R6: A tap count of zero ends the run with `done` and no `error`, and no request is raised.
- R7: When 2N is greater than or equal to MASK_W, the sweep is skipped and the run ends with `done`, no `error` and no request. For MASK_W=32 the limit is N=15, which still sweeps 30 probes.
- R8: Tuning runs only for `busMode` codes 2, 3 and 4 (the 200 MHz eMMC mode, SDR104 and SDR50). Any other code gives `done` without `error` on the first cycle after start, raises no request and leaves the tuning state unchanged.
- R9: After the last probe, `maskValid` stays high and both masks stay stable until `selDone`. Mask bits at positions 2N and above read 0.
- R10: If the selector answers with `selOk`=1, `tapPos` takes `selTap`, `autoRetuneEn` goes to 1 and the run ends with `done` and no `error`.
- R11: If the selector answers with `selOk`=0, the run ends with `done` and `error`. At that time `tapSelEn`, `hs400En`, `hs400Osel` and `autoRetuneEn` are all 0. `hs400Val` bit 1 loads `hs400En` and bit 0 loads `hs400Osel`.
- R12: A start pulse while a run is in progress is ignored: the sweep keeps its latched tap count, and only one `done` is produced.
- R13: After reset, `cmdReq`, `maskValid`, `busy`, `done`, `error`, `tapPos` and all four tuning-state bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that starts a tuning run |
| busMode | input | 3 | Current bus mode code |
| tapCount | input | CNT_W | Tap count reported by the delay line |
| hs400Load | input | 1 | Loads the two HS400 state bits |
| hs400Val | input | 2 | Bit 1 is the enable, bit 0 is the output select |
| cmdReq | output | 1 | Request for one tuning command |
| cmdAck | input | 1 | Command engine has finished the command |
| cmdErr | input | 1 | Command finished with an error (valid with cmdAck) |
| cmpResult | input | CMP_W | Sampled-data comparison; zero means no mismatch |
| tapPos | output | CNT_W | Programmed sampling tap |
| passMask | output | MASK_W | Per-probe command success bits |
| matchMask | output | MASK_W | Per-probe comparison match bits |
| maskValid | output | 1 | Masks are complete and offered to the selector |
| selDone | input | 1 | Selector has answered |
| selOk | input | 1 | Selector found a usable window |
| selTap | input | CNT_W | Tap chosen by the selector |
| tapSelEn | output | 1 | Tap selection enabled |
| hs400En | output | 1 | HS400 enable state bit |
| hs400Osel | output | 1 | HS400 output select state bit |
| autoRetuneEn | output | 1 | Automatic re-tuning enabled |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run failed (valid with done) |

## Verification
A wrong probe index or tap counter shows up at `tapPos` while the very next request is raised, and as a misplaced bit in the masks when `maskValid` rises. A settle counter that is off by one changes the low time of `cmdReq` between two probes. The bench measures that low time for every probe in a sweep. A state machine that takes a wrong branch shows up within a cycle or two, as a request where none was due, a missing `done`, an early `done`, or tuning-state bits that are still set when `error` is reported.

// File: rtl/tap_sweep_pkg.sv
package tap_sweep_pkg;

  typedef enum logic [2:0] {
    BM_LEGACY = 3'd0,
    BM_HS     = 3'd1,
    BM_HS200  = 3'd2,
    BM_SDR104 = 3'd3,
    BM_SDR50  = 3'd4,
    BM_DDR50  = 3'd5,
    BM_HS400  = 3'd6,
    BM_RSVD   = 3'd7
  } busMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PROBE,
    ST_REQ,
    ST_SETTLE,
    ST_SELECT,
    ST_DONE_OK,
    ST_DONE_ERR
  } sweepState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadCount;
    logic progTap;
    logic record;
    logic settleClr;
    logic settleInc;
    logic advance;
    logic applySel;
    logic failReset;
  } tapCtl_t;

  function automatic logic needsTuning(input logic [2:0] mode);
    return (mode == BM_HS200) || (mode == BM_SDR104) || (mode == BM_SDR50);
  endfunction

endpackage

// File: rtl/tap_sweep_ctrl.sv
module tap_sweep_ctrl
  import tap_sweep_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  busMode,
  input  logic        cntZero,
  input  logic        cntTooBig,
  input  logic        lastProbe,
  input  logic        settleDone,
  input  logic        cmdAck,
  input  logic        selDone,
  input  logic        selOk,
  output tapCtl_t     ctl,
  output logic        cmdReq,
  output logic        maskValid,
  output logic        busy,
  output logic        done,
  output logic        error
);

  sweepState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (needsTuning(busMode)) begin
            ctl.loadCount = 1'b1;
            stateNext     = ST_CHECK;
          end else begin
            stateNext = ST_DONE_OK;
          end
        end
      end
      ST_CHECK: begin
        if (cntZero || cntTooBig) stateNext = ST_DONE_OK;
        else                      stateNext = ST_PROBE;
      end
      ST_PROBE: begin
        ctl.progTap = 1'b1;
        stateNext   = ST_REQ;
      end
      ST_REQ: begin
        if (cmdAck) begin
          ctl.record    = 1'b1;
          ctl.settleClr = 1'b1;
          stateNext     = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (settleDone) begin
          if (lastProbe) begin
            stateNext = ST_SELECT;
          end else begin
            ctl.advance = 1'b1;
            stateNext   = ST_PROBE;
          end
        end else begin
          ctl.settleInc = 1'b1;
        end
      end
      ST_SELECT: begin
        if (selDone) begin
          if (selOk) begin
            ctl.applySel = 1'b1;
            stateNext    = ST_DONE_OK;
          end else begin
            ctl.failReset = 1'b1;
            stateNext     = ST_DONE_ERR;
          end
        end
      end
      ST_DONE_OK:  stateNext = ST_IDLE;
      ST_DONE_ERR: stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  assign cmdReq    = (state == ST_REQ);
  assign maskValid = (state == ST_SELECT);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE_OK) || (state == ST_DONE_ERR);
  assign error     = (state == ST_DONE_ERR);

  AST_REQ_HELD_TO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq && !cmdAck |=> cmdReq); // R2

  AST_MASK_HELD_TO_SEL: assert property (@(posedge clk) disable iff (!rstN)
    maskValid && !selDone |=> maskValid); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12

  AST_ERR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done); // R11

endmodule

// File: rtl/tap_sweep_dp.sv
module tap_sweep_dp
  import tap_sweep_pkg::*;
#(
  parameter int MASK_W     = 32,
  parameter int CNT_W      = 8,
  parameter int CMP_W      = 32,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tapCtl_t           ctl,
  input  logic [CNT_W-1:0]  tapCount,
  input  logic              cmdErr,
  input  logic [CMP_W-1:0]  cmpResult,
  input  logic [CNT_W-1:0]  selTap,
  input  logic              hs400Load,
  input  logic [1:0]        hs400Val,
  input  logic              cmdReq,
  input  logic              maskValid,
  output logic [CNT_W-1:0]  tapPos,
  output logic [MASK_W-1:0] passMask,
  output logic [MASK_W-1:0] matchMask,
  output logic              tapSelEn,
  output logic              hs400En,
  output logic              hs400Osel,
  output logic              autoRetuneEn,
  output logic              cntZero,
  output logic              cntTooBig,
  output logic              lastProbe,
  output logic              settleDone
);

  localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;
  localparam int TW    = CNT_W + 1;
  localparam int SW    = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] tapIdx;
  logic [CNT_W-1:0] tapNext;
  logic [IDX_W-1:0] probeIdx;
  logic [SW-1:0]    settleCnt;
  logic [TW-1:0]    twiceCnt;

  assign twiceCnt   = {cntReg, 1'b0};
  assign tapNext    = tapIdx + 1'b1;
  assign cntZero    = (cntReg == '0);
  assign cntTooBig  = (twiceCnt >= TW'(MASK_W));
  assign lastProbe  = (TW'(probeIdx) == twiceCnt - 1'b1);
  assign settleDone = (settleCnt == SW'(SETTLE_CYC - 1));

  // Sweep counters and latched tap count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg   <= '0;
      tapIdx   <= '0;
      probeIdx <= '0;
    end else if (ctl.loadCount) begin
      cntReg   <= tapCount;
      tapIdx   <= '0;
      probeIdx <= '0;
    end else if (ctl.advance) begin
      probeIdx <= probeIdx + 1'b1;
      tapIdx   <= (tapNext == cntReg) ? '0 : tapNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              settleCnt <= '0;
    else if (ctl.settleClr) settleCnt <= '0;
    else if (ctl.settleInc) settleCnt <= settleCnt + 1'b1;
  end

  // One result bit per probe in each mask.
  for (genvar b = 0; b < MASK_W; b++) begin : g_maskBit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        passMask[b]  <= 1'b0;
        matchMask[b] <= 1'b0;
      end else if (ctl.loadCount) begin
        passMask[b]  <= 1'b0;
        matchMask[b] <= 1'b0;
      end else if (ctl.record && (probeIdx == IDX_W'(b))) begin
        passMask[b]  <= !cmdErr;
        matchMask[b] <= (cmpResult == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tapPos <= '0;
    else if (ctl.applySel) tapPos <= selTap;
    else if (ctl.progTap)  tapPos <= tapIdx;
  end

  // Tuning state; a failure clears everything and wins over a load.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapSelEn     <= 1'b0;
      hs400En      <= 1'b0;
      hs400Osel    <= 1'b0;
      autoRetuneEn <= 1'b0;
    end else if (ctl.failReset) begin
      tapSelEn     <= 1'b0;
      hs400En      <= 1'b0;
      hs400Osel    <= 1'b0;
      autoRetuneEn <= 1'b0;
    end else begin
      if (ctl.loadCount) begin
        tapSelEn     <= 1'b1;
        autoRetuneEn <= 1'b0;
      end
      if (ctl.applySel) autoRetuneEn <= 1'b1;
      if (hs400Load) begin
        hs400En   <= hs400Val[1];
        hs400Osel <= hs400Val[0];
      end
    end
  end

  AST_TAP_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq |-> (tapPos < cntReg)); // R1

  AST_PASS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    maskValid && $past(maskValid) |-> $stable(passMask) && $stable(matchMask)); // R9

  AST_TAP_STEADY_IN_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq && $past(cmdReq) |-> $stable(tapPos)); // R1

endmodule

// File: rtl/tap_sweep_seq.sv
module tap_sweep_seq
  import tap_sweep_pkg::*;
#(
  parameter int MASK_W     = 32,
  parameter int CNT_W      = 8,
  parameter int CMP_W      = 32,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        busMode,
  input  logic [CNT_W-1:0]  tapCount,
  input  logic              hs400Load,
  input  logic [1:0]        hs400Val,
  output logic              cmdReq,
  input  logic              cmdAck,
  input  logic              cmdErr,
  input  logic [CMP_W-1:0]  cmpResult,
  output logic [CNT_W-1:0]  tapPos,
  output logic [MASK_W-1:0] passMask,
  output logic [MASK_W-1:0] matchMask,
  output logic              maskValid,
  input  logic              selDone,
  input  logic              selOk,
  input  logic [CNT_W-1:0]  selTap,
  output logic              tapSelEn,
  output logic              hs400En,
  output logic              hs400Osel,
  output logic              autoRetuneEn,
  output logic              busy,
  output logic              done,
  output logic              error
);

  tapCtl_t ctl;
  logic    cntZero, cntTooBig, lastProbe, settleDone;

  tap_sweep_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .busMode    (busMode),
    .cntZero    (cntZero),
    .cntTooBig  (cntTooBig),
    .lastProbe  (lastProbe),
    .settleDone (settleDone),
    .cmdAck     (cmdAck),
    .selDone    (selDone),
    .selOk      (selOk),
    .ctl        (ctl),
    .cmdReq     (cmdReq),
    .maskValid  (maskValid),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  tap_sweep_dp #(
    .MASK_W     (MASK_W),
    .CNT_W      (CNT_W),
    .CMP_W      (CMP_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .tapCount     (tapCount),
    .cmdErr       (cmdErr),
    .cmpResult    (cmpResult),
    .selTap       (selTap),
    .hs400Load    (hs400Load),
    .hs400Val     (hs400Val),
    .cmdReq       (cmdReq),
    .maskValid    (maskValid),
    .tapPos       (tapPos),
    .passMask     (passMask),
    .matchMask    (matchMask),
    .tapSelEn     (tapSelEn),
    .hs400En      (hs400En),
    .hs400Osel    (hs400Osel),
    .autoRetuneEn (autoRetuneEn),
    .cntZero      (cntZero),
    .cntTooBig    (cntTooBig),
    .lastProbe    (lastProbe),
    .settleDone   (settleDone)
  );

  AST_FAIL_CLEARS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !tapSelEn && !hs400En && !hs400Osel && !autoRetuneEn); // R11

  AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdReq && !maskValid); // R8

endmodule

// File: tb/tap_sweep_seq_tb.sv
`timescale 1ns/1ps
module tap_sweep_seq_tb;

  localparam int SETTLE  = 4;
  localparam int ACK_LAT = 2;
  localparam int SEL_LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  busMode = 3'd0;
  logic [7:0]  tapCount = 8'd0;
  logic        hs400Load = 1'b0;
  logic [1:0]  hs400Val = 2'b00;
  logic        cmdReq;
  logic        cmdAck = 1'b0;
  logic        cmdErr = 1'b0;
  logic [31:0] cmpResult = 32'd0;
  logic [7:0]  tapPos;
  logic [31:0] passMask, matchMask;
  logic        maskValid;
  logic        selDone = 1'b0;
  logic        selOk = 1'b0;
  logic [7:0]  selTap = 8'd0;
  logic        tapSelEn, hs400En, hs400Osel, autoRetuneEn;
  logic        busy, done, error;

  tap_sweep_seq #(.MASK_W(32), .CNT_W(8), .CMP_W(32), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .busMode(busMode), .tapCount(tapCount),
    .hs400Load(hs400Load), .hs400Val(hs400Val), .cmdReq(cmdReq), .cmdAck(cmdAck),
    .cmdErr(cmdErr), .cmpResult(cmpResult), .tapPos(tapPos), .passMask(passMask),
    .matchMask(matchMask), .maskValid(maskValid), .selDone(selDone), .selOk(selOk),
    .selTap(selTap), .tapSelEn(tapSelEn), .hs400En(hs400En), .hs400Osel(hs400Osel),
    .autoRetuneEn(autoRetuneEn), .busy(busy), .done(done), .error(error)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;

  // Responder and selector state
  logic [31:0] passPat = '0, matchPat = '0;
  logic [7:0]  tapSeen [32];
  int          probeNo = 0;
  int          ackWait = 0;
  int          lowRun = 0;
  int          gapMin = 999, gapMax = 0;
  int          selWait = 0;
  logic        cfgOk = 1'b0;
  logic [7:0]  cfgTap = '0;
  logic [31:0] firstPass = '0, lastPass = '0, firstMatch = '0, lastMatch = '0;
  int          doneCount = 0;
  logic        gotErr = 1'b0;
  int          doneLat = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Command engine model.
  always @(negedge clk) begin
    if (!cmdReq) lowRun++;
    if (cmdReq && lowRun > 0) begin
      if (probeNo > 0) begin
        if (lowRun < gapMin) gapMin = lowRun;
        if (lowRun > gapMax) gapMax = lowRun;
      end
      lowRun = 0;
    end
    if (cmdAck) begin
      cmdAck = 1'b0;
    end else if (cmdReq) begin
      if (ackWait == ACK_LAT) begin
        if (probeNo < 32) begin
          tapSeen[probeNo] = tapPos;
          cmdErr    = ~passPat[probeNo];
          cmpResult = matchPat[probeNo] ? 32'd0 : (32'h1 << (probeNo % 32));
        end
        cmdAck  = 1'b1;
        probeNo++;
        ackWait = 0;
      end else begin
        ackWait++;
      end
    end
  end

  // Window selector model.
  always @(negedge clk) begin
    if (selDone) begin
      selDone = 1'b0;
    end else if (maskValid) begin
      if (selWait == 0) begin
        firstPass  = passMask;
        firstMatch = matchMask;
      end
      lastPass  = passMask;
      lastMatch = matchMask;
      if (selWait == SEL_LAT) begin
        selDone = 1'b1;
        selOk   = cfgOk;
        selTap  = cfgTap;
        selWait = 0;
      end else begin
        selWait++;
      end
    end
  end

  always @(negedge clk) if (done) doneCount++;

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  task automatic runTune(input logic [2:0] mode, input logic [7:0] n,
                         input logic okIn, input logic [7:0] tapIn, input bit midStart);
    bit midDone = 0;
    int lat;
    probeNo = 0; ackWait = 0; gapMin = 999; gapMax = 0; doneCount = 0;
    cfgOk = okIn; cfgTap = tapIn;
    @(negedge clk);
    busMode = mode; tapCount = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin
      if (midStart && !midDone && probeNo == 3) begin
        start = 1'b1; tapCount = 8'd5; midDone = 1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk("run reached done", done, 1'b1);
    gotErr  = error;
    doneLat = lat;
  endtask

  task automatic checkSweep(input string tag, input int n);
    logic [31:0] keep;
    keep = (32'h1 << (2 * n)) - 1;
    chk({tag, " R1 probe count"}, probeNo, 2 * n);
    for (int i = 0; i < 2 * n; i++)
      if (tapSeen[i] != 8'(i % n)) chk({tag, " R1 tap order"}, tapSeen[i], i % n);
    chk({tag, " R3 passMask"}, firstPass, passPat & keep);
    chk({tag, " R4 matchMask"}, firstMatch, matchPat & keep);
    chk({tag, " R9 masks held"}, {lastPass, lastMatch}, {firstPass, firstMatch});
    chk({tag, " R5 gap min"}, gapMin, SETTLE + 1);
    chk({tag, " R5 gap max"}, gapMax, SETTLE + 1);
  endtask

  task automatic testReset;
    chk("R13 reset outputs",
        {cmdReq, maskValid, busy, done, error, tapSelEn, hs400En, hs400Osel, autoRetuneEn},
        9'b0);
    chk("R13 reset tapPos", tapPos, 8'd0);
  endtask

  task automatic testSweepPass;
    passPat  = 32'hA5A5_3FCE;
    matchPat = 32'hFFFF_0F0F;
    runTune(3'd2, 8'd8, 1'b1, 8'd6, 1'b1);   // second start mid-sweep (R12)
    chk("R10 error low", gotErr, 1'b0);
    @(negedge clk);
    checkSweep("n8", 8);
    chk("R12 single done", doneCount, 1);
    chk("R10 tapPos from selector", tapPos, 8'd6);
    chk("R10 autoRetuneEn", autoRetuneEn, 1'b1);
    chk("R10 tapSelEn", tapSelEn, 1'b1);
    chk("R2 idle after run", {cmdReq, busy}, 2'b00);
  endtask

  task automatic testSweepFail;
    @(negedge clk);
    hs400Load = 1'b1; hs400Val = 2'b11;
    @(negedge clk);
    hs400Load = 1'b0;
    chk("R11 hs400 loaded", {hs400En, hs400Osel}, 2'b11);
    passPat  = 32'h0000_002D;
    matchPat = 32'h0000_0012;
    runTune(3'd4, 8'd3, 1'b0, 8'd1, 1'b0);
    chk("R11 error flagged", gotErr, 1'b1);
    chk("R11 state cleared", {tapSelEn, hs400En, hs400Osel, autoRetuneEn}, 4'b0000);
    @(negedge clk);
    checkSweep("n3", 3);
  endtask

  task automatic testNoTuneMode;
    runTune(3'd1, 8'd8, 1'b1, 8'd2, 1'b0);
    chk("R8 done on first cycle", doneLat, 1);
    chk("R8 no error", gotErr, 1'b0);
    chk("R8 no probes", probeNo, 0);
    chk("R8 state untouched", {tapSelEn, autoRetuneEn}, 2'b00);
    runTune(3'd6, 8'd8, 1'b1, 8'd2, 1'b0);
    chk("R8 hs400 code no probes", {probeNo[7:0], 7'd0, gotErr}, 16'd0);
  endtask

  task automatic testZeroTaps;
    runTune(3'd3, 8'd0, 1'b1, 8'd2, 1'b0);
    chk("R6 no error", gotErr, 1'b0);
    chk("R6 no probes", probeNo, 0);
  endtask

  task automatic testMaskLimit;
    runTune(3'd2, 8'd16, 1'b1, 8'd2, 1'b0);
    chk("R7 n16 skipped", probeNo, 0);
    chk("R7 n16 no error", gotErr, 1'b0);
    passPat  = 32'hFFFF_FF7E;
    matchPat = 32'h5555_AAAA;
    runTune(3'd3, 8'd15, 1'b1, 8'd14, 1'b0);
    chk("R7 n15 no error", gotErr, 1'b0);
    @(negedge clk);
    checkSweep("n15", 15);
    chk("R10 n15 tapPos", tapPos, 8'd14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testSweepPass();
    testSweepFail();
    testNoTuneMode();
    testZeroTaps();
    testMaskLimit();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule